// File: doc/BRIEF.md
# Page-Group Bank Selector with Speed-Mode Decode

This block sits beside the instruction fetch path of a replacement processor board. It holds the bank choice for each bankable group of a sixteen-page instruction address space. Whenever a fetched word carries one of the four bank-enable opcodes, the block switches the group that owns the fetched page. Every page then shows the bank it currently maps to, and memory lookup logic further down uses that value. Pages 0x0 to 0x3 belong to the operating system and always read bank 1. Page 0x5 is tied to page 0x3, so a switch fetched from either of them moves page 0x5 only. Pages 0x4, 0x6 and 0x7 each have their own register. Each port pair 0x8/0x9, 0xA/0xB, 0xC/0xD and 0xE/0xF shares one register.

The same fetched word also carries a two-bit speed field. From it the block registers a speed mode: turbo (only while a global turbo enable is high), normal, or refetch. When the board enters deep sleep, every bank choice returns to bank 1.

Top module: `pgb_top`

## Requirements
- R1: While reset is asserted, every page reports bank code 0 (bank 1) and the speed mode is 0 (normal).
- R2: A fetch whose bits 9:0 equal 0x100, 0x180, 0x140 or 0x1C0 sets its group's bank code to 0, 1, 2 or 3 respectively. The new code is visible in the cycle after the strobe. Page p occupies bits [2p+1:2p] of the bank output.
- R3: A word presented with the fetch strobe low changes no bank code and does not change the speed mode.
- R4: Pages 0x0, 0x1 and 0x2 never leave code 0, and a bank-enable opcode fetched from them changes no page.
- R5: A bank-enable opcode fetched from page 0x3 or page 0x5 updates page 0x5. Page 0x3 stays at code 0.
- R6: In each port pair, both pages always show one shared code, and a switch fetched from either page of the pair updates both.
- R7: A switch changes only the group of the fetched page. All other groups keep their codes.
- R8: Bits 15:14 and 11:10 of the fetched word have no effect on bank or speed decoding.
- R9: On each strobed fetch, the speed mode becomes 0 (normal) when bits 13:12 are 01, and 2 (refetch) when bit 13 is 1.
- R10: Bits 13:12 = 00 give mode 1 (turbo) only if the turbo enable is high in that cycle. Otherwise they give mode 0.
- R11: A deep-sleep cycle returns every page to code 0 in the following cycle. It takes priority over a bank switch strobed in the same cycle, and it leaves the speed decode of that fetch in effect.
- R12: A strobed word whose bits 9:0 are not one of the four opcodes leaves every bank code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch strobe |
| fetch_page | input | 4 | Page field (top four bits) of the fetch address |
| fetch_word | input | 16 | Extended fetched word |
| sleep_in | input | 1 | Deep-sleep entry indication |
| turbo_en | input | 1 | Global turbo permission |
| page_bank | output | 32 | Two-bit bank code per page, page p at [2p+1:2p] |
| spd_mode | output | 2 | 0 normal, 1 turbo, 2 refetch |

## Verification
A deep-sleep indication can arrive in the same cycle as a strobed bank-enable fetch that also carries a speed field. The bench drives exactly that combination, first at a port pair and then at page 0x5. It expects every bank code to be 0 in the next cycle while the speed mode follows the fetched word. The reference model is stepped with the same inputs and compared on every clock. It applies the sleep clear after the switch, so a design that lets the switch win is reported.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  localparam int PGB_PAGES  = 16;
  localparam int PGB_GROUPS = 8;
  localparam int PGB_BANK_W = 2;
  localparam int PGB_WORD_W = 16;

  typedef enum logic [1:0] {
    SPD_NORMAL  = 2'd0,
    SPD_TURBO   = 2'd1,
    SPD_REFETCH = 2'd2
  } spd_t;

  typedef struct packed {
    logic       hit;
    logic [1:0] bank;
  } bsel_t;

  // Pages that own or feed a bank register (0x3 feeds the 0x5 register).
  function automatic logic page_switchable(input logic [3:0] pg);
    return (pg >= 4'h3);
  endfunction

  // Pages whose output follows a register (0x3 is locked to bank 1).
  function automatic logic page_visible(input logic [3:0] pg);
    return (pg >= 4'h4);
  endfunction

  // Group index: 0=p4 1=p3/p5 2=p6 3=p7 4..7=port pairs
  function automatic logic [2:0] page_group(input logic [3:0] pg);
    logic [2:0] g;
    case (pg)
      4'h4:       g = 3'd0;
      4'h3, 4'h5: g = 3'd1;
      4'h6:       g = 3'd2;
      4'h7:       g = 3'd3;
      default:    g = (pg >= 4'h8) ? {1'b1, pg[2:1]} : 3'd0;
    endcase
    return g;
  endfunction

  function automatic bsel_t decode_bank(input logic [9:0] ins);
    bsel_t r;
    r.hit  = (ins[9:8] == 2'b01) && (ins[5:0] == 6'd0);
    r.bank = {ins[6], ins[7]};
    return r;
  endfunction

  function automatic spd_t decode_speed(input logic [1:0] sb, input logic ten);
    spd_t m;
    if (sb[1])      m = SPD_REFETCH;
    else if (sb[0]) m = SPD_NORMAL;
    else            m = ten ? SPD_TURBO : SPD_NORMAL;
    return m;
  endfunction
endpackage

// File: rtl/pgb_opcode_dec.sv
module pgb_opcode_dec
  import pgb_pkg::*;
#(
  parameter int WORD_W = PGB_WORD_W,
  parameter int BANK_W = PGB_BANK_W
)(
  input  logic [WORD_W-1:0] word,
  input  logic [3:0]        page,
  input  logic              turbo_en,
  output logic              sw_hit,
  output logic [BANK_W-1:0] sw_bank,
  output logic [2:0]        sw_group,
  output spd_t              spd_next
);
  localparam int INS_W = 10;
  bsel_t dec;
  logic  rsv_unused;

  assign rsv_unused = ^{word[WORD_W-1:WORD_W-2], word[INS_W+1:INS_W]};

  always_comb begin
    dec      = decode_bank(word[INS_W-1:0]);
    sw_hit   = dec.hit && page_switchable(page);
    sw_bank  = BANK_W'(dec.bank);
    sw_group = page_group(page);
    spd_next = decode_speed(word[INS_W+3:INS_W+2], turbo_en);
  end
endmodule

// File: rtl/pgb_group_regs.sv
module pgb_group_regs
  import pgb_pkg::*;
#(
  parameter int GROUPS = PGB_GROUPS,
  parameter int BANK_W = PGB_BANK_W
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep_in,
  input  logic [GROUPS-1:0]        wr_en,
  input  logic [BANK_W-1:0]        wr_bank,
  output logic [GROUPS*BANK_W-1:0] grp_bank
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_reg
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (sleep_in) q <= '0;
      else if (wr_en[g]) q <= wr_bank;
    end
    assign grp_bank[g*BANK_W +: BANK_W] = q;
  end
endmodule

// File: rtl/pgb_page_map.sv
module pgb_page_map
  import pgb_pkg::*;
#(
  parameter int PAGES  = PGB_PAGES,
  parameter int GROUPS = PGB_GROUPS,
  parameter int BANK_W = PGB_BANK_W
)(
  input  logic [GROUPS*BANK_W-1:0] grp_bank,
  output logic [PAGES*BANK_W-1:0]  page_bank
);
  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam logic [3:0] PG  = 4'(p);
    localparam int         GRP = int'(page_group(PG));
    if (page_visible(PG)) begin : g_map
      assign page_bank[p*BANK_W +: BANK_W] = grp_bank[GRP*BANK_W +: BANK_W];
    end else begin : g_fixed
      assign page_bank[p*BANK_W +: BANK_W] = '0;
    end
  end
endmodule

// File: rtl/pgb_top.sv
module pgb_top
  import pgb_pkg::*;
#(
  parameter int PAGES  = PGB_PAGES,
  parameter int GROUPS = PGB_GROUPS,
  parameter int BANK_W = PGB_BANK_W,
  parameter int WORD_W = PGB_WORD_W
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_vld,
  input  logic [3:0]              fetch_page,
  input  logic [WORD_W-1:0]       fetch_word,
  input  logic                    sleep_in,
  input  logic                    turbo_en,
  output logic [PAGES*BANK_W-1:0] page_bank,
  output logic [1:0]              spd_mode
);
  localparam int GRP_W = $clog2(GROUPS);

  logic                     sw_hit;
  logic [BANK_W-1:0]        sw_bank;
  logic [2:0]               sw_group;
  spd_t                     spd_next;
  spd_t                     spd_q;
  logic [GROUPS-1:0]        grp_wr;
  logic [GROUPS*BANK_W-1:0] grp_bank;

  pgb_opcode_dec #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_dec (
    .word(fetch_word), .page(fetch_page), .turbo_en(turbo_en),
    .sw_hit(sw_hit), .sw_bank(sw_bank), .sw_group(sw_group),
    .spd_next(spd_next)
  );

  always_comb begin
    grp_wr = '0;
    for (int g = 0; g < GROUPS; g++)
      grp_wr[g] = fetch_vld && sw_hit && (GRP_W'(sw_group) == GRP_W'(g));
  end

  pgb_group_regs #(.GROUPS(GROUPS), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in),
    .wr_en(grp_wr), .wr_bank(sw_bank), .grp_bank(grp_bank)
  );

  pgb_page_map #(.PAGES(PAGES), .GROUPS(GROUPS), .BANK_W(BANK_W)) u_map (
    .grp_bank(grp_bank), .page_bank(page_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         spd_q <= SPD_NORMAL;
    else if (fetch_vld) spd_q <= spd_next;
  end
  assign spd_mode = spd_q;
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
  parameter int GROUPS = 8,
  parameter int BANK_W = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic [3:0]        fetch_page,
  input logic [15:0]       fetch_word,
  input logic              sleep_in,
  input logic              turbo_en,
  input logic [31:0]       page_bank,
  input logic [1:0]        spd_mode,
  input logic [GROUPS-1:0] grp_wr,
  input logic              sw_hit,
  input logic [BANK_W-1:0] sw_bank
);
  assert_one_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_wr));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld && !sleep_in) |=> $stable(page_bank) && $stable(spd_mode));

  assert_sleep_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_in |=> (page_bank == '0));

  assert_os_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_bank[5:0] == 6'd0);

  assert_linked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !sleep_in && sw_hit && fetch_page == 4'h3)
    |=> (page_bank[11:10] == $past(sw_bank)) && (page_bank[7:6] == 2'd0));

  assert_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !sleep_in && sw_hit && fetch_page == 4'h9)
    |=> (page_bank[17:16] == $past(sw_bank)) && (page_bank[19:18] == $past(sw_bank)));

  assert_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_word[13]) |=> (spd_mode == 2'd2));

  assert_turbo_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !turbo_en) |=> (spd_mode != 2'd1));
endmodule

bind pgb_top pgb_checker #(.GROUPS(GROUPS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_page(fetch_page),
  .fetch_word(fetch_word), .sleep_in(sleep_in), .turbo_en(turbo_en),
  .page_bank(page_bank), .spd_mode(spd_mode), .grp_wr(grp_wr),
  .sw_hit(sw_hit), .sw_bank(sw_bank)
);

// File: tb/pgb_top_test.sv
module pgb_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [3:0]  fetch_page = 4'h0;
  logic [15:0] fetch_word = 16'h0;
  logic        sleep_in = 1'b0;
  logic        turbo_en = 1'b0;
  logic [31:0] page_bank;
  logic [1:0]  spd_mode;

  int checks = 0;
  int errors = 0;
  int mg[8];
  int mmode = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pgb_top uut (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_page(fetch_page),
    .fetch_word(fetch_word), .sleep_in(sleep_in), .turbo_en(turbo_en),
    .page_bank(page_bank), .spd_mode(spd_mode)
  );

  function automatic int ref_group(int p);
    if (p >= 8) return 4 + (p - 8) / 2;
    if (p == 3 || p == 5) return 1;
    if (p == 4) return 0;
    if (p == 6) return 2;
    if (p == 7) return 3;
    return -1;
  endfunction

  function automatic int ref_bank(int ins);
    if (ins == 'h100) return 0;
    if (ins == 'h180) return 1;
    if (ins == 'h140) return 2;
    if (ins == 'h1C0) return 3;
    return -1;
  endfunction

  task automatic model_step(int p, int w, bit v, bit s, bit t);
    int g = ref_group(p);
    int b = ref_bank(w % 1024);
    if (v && g >= 0 && b >= 0) mg[g] = b;
    if (s) foreach (mg[i]) mg[i] = 0;
    if (v) begin
      case ((w / 4096) % 4)
        0: mmode = t ? 1 : 0;
        1: mmode = 0;
        default: mmode = 2;
      endcase
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 16; p++) begin
      int exp_b = (p < 4) ? 0 : mg[ref_group(p)];
      int act_b = int'(page_bank[2*p +: 2]);
      checks++;
      if (act_b != exp_b) begin
        errors++;
        $display("FAIL %s page %0h bank actual %0d expected %0d", tag, p, act_b, exp_b);
      end
    end
    checks++;
    if (int'(spd_mode) != mmode) begin
      errors++;
      $display("FAIL %s speed mode actual %0d expected %0d", tag, spd_mode, mmode);
    end
  endtask

  task automatic step(int p, int w, bit v, bit s, bit t, string req);
    tag = req;
    fetch_page = 4'(p); fetch_word = 16'(w);
    fetch_vld = v; sleep_in = s; turbo_en = t;
    @(posedge clk);
    #1 model_step(p, w, v, s, t);
    @(negedge clk);
    fetch_vld = 1'b0; sleep_in = 1'b0;
    compare();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired during %s", tag);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (mg[i]) mg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();
    // R2: four opcodes at page 0x4
    step(4, 'h1180, 1, 0, 0, "R2");
    step(4, 'h1140, 1, 0, 0, "R2");
    step(4, 'h11C0, 1, 0, 0, "R2");
    step(4, 'h1100, 1, 0, 0, "R2");
    step(6, 'h11C0, 1, 0, 0, "R2");
    // R3: strobe low
    step(6, 'h1140, 0, 0, 1, "R3");
    step(7, 'h0180, 0, 0, 1, "R3");
    // R4: OS pages
    step(0, 'h11C0, 1, 0, 0, "R4");
    step(1, 'h1180, 1, 0, 0, "R4");
    step(2, 'h1140, 1, 0, 0, "R4");
    // R5: linked 0x3/0x5
    step(3, 'h11C0, 1, 0, 0, "R5");
    step(5, 'h1180, 1, 0, 0, "R5");
    step(3, 'h1140, 1, 0, 0, "R5");
    // R6: port pairs from either member
    step(9, 'h1140, 1, 0, 0, "R6");
    step(8, 'h1180, 1, 0, 0, "R6");
    step(14, 'h11C0, 1, 0, 0, "R6");
    step(15, 'h1140, 1, 0, 0, "R6");
    // R7: distinct codes across groups, then one change
    step(10, 'h1180, 1, 0, 0, "R7");
    step(13, 'h11C0, 1, 0, 0, "R7");
    step(7, 'h1140, 1, 0, 0, "R7");
    step(11, 'h1100, 1, 0, 0, "R7");
    // R8: reserved bits set
    step(12, 'hCD40, 1, 0, 1, "R8");
    step(4, 'h5D80, 1, 0, 0, "R8");
    step(6, 'hFEC0, 1, 0, 0, "R8");
    // R9 / R10: speed field
    step(0, 'h1000, 1, 0, 1, "R9");
    step(0, 'h2000, 1, 0, 1, "R9");
    step(0, 'h3000, 1, 0, 0, "R9");
    step(0, 'h0000, 1, 0, 1, "R10");
    step(0, 'hC000, 1, 0, 0, "R10");
    step(0, 'h0C00, 1, 0, 1, "R10");
    // R12: non-opcode words
    step(6, 'h1101, 1, 0, 0, "R12");
    step(9, 'h10C0, 1, 0, 0, "R12");
    step(5, 'h1000, 1, 0, 0, "R12");
    // R11: sleep alone and sleep with a same-cycle switch
    step(0, 'h0000, 0, 1, 0, "R11");
    step(8, 'h1180, 1, 0, 0, "R11");
    step(5, 'h11C0, 1, 0, 0, "R11");
    step(9, 'h21C0, 1, 1, 0, "R11");
    step(5, 'h0140, 1, 0, 1, "R11");
    step(5, 'h1180, 1, 1, 1, "R11");
    step(5, 'h0000, 0, 0, 0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule